// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block sits on the byte path of a NAND flash controller and builds Hamming parity over the data as it passes through. Each byte has a position inside a 256-byte segment. Each data bit then has an 11-bit location: the byte's 8-bit offset in the upper bits and the bit's index within the byte in the low 3 bits. For every segment the block keeps two 11-bit parity words. Word A bit k is the XOR of every data bit whose location has bit k set. Word B bit k is the XOR of every data bit whose location has bit k clear. A correction stage elsewhere can compare these words with stored codes to find and flip a single failing bit.

Two unit sizes are supported. In single mode, one 256-byte segment gives one pair of words, which is 3 code bytes. In dual mode, a 512-byte unit is split into two independent 256-byte segments, each with its own pair of words, which is 6 code bytes. A clear pulse must come before every page. It zeroes the parity and the byte count, and it captures the unit size for the coming page. After the last byte of the unit is accepted, a done flag rises and the words stay frozen until the next clear.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset all four parity words and both packed codes are zero, done is 0 and the block is in single mode.
- R2: Word A of a segment has, in bit k, the XOR of all data bits whose location {byte offset[7:0], bit index[2:0]} has bit k equal to 1. The bit index of data bit n of a byte is n, and a byte's offset is its arrival order within its segment, starting at 0.
- R3: Word B of a segment has, in bit k, the XOR of all data bits whose location has bit k equal to 0.
- R4: The unit size is sampled from seg512 during the clear pulse (0 = single, 1 = dual) and holds until the next clear. In single mode done rises after the 256th accepted byte, and the second segment's words stay zero.
- R5: In dual mode, accepted bytes 0 to 255 update the first segment's words and bytes 256 to 511 update the second segment's words, at offsets 0 to 255. Done rises after the 512th accepted byte.
- R6: A cycle with byte_valid low changes no parity word, no count and not done, whatever byte_data holds.
- R7: While done is 1, arriving bytes are ignored until the next clear.
- R8: A clear zeroes all words, the byte count and done one cycle later. A byte presented in the same cycle as the clear is dropped.
- R9: Each packed code is 22 bits with word A in bits 10:0 and word B in bits 21:11. Its code bytes, least significant first, are bits 7:0, 15:8 and 21:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Per-page clear pulse; also samples seg512 |
| seg512 | input | 1 | Unit size select: 1 = two 256-byte segments |
| byte_valid | input | 1 | byte_data holds a byte of the page this cycle |
| byte_data | input | 8 | Data byte |
| ecc_a0 | output | 11 | Segment 0 word A |
| ecc_b0 | output | 11 | Segment 0 word B |
| ecc_a1 | output | 11 | Segment 1 word A |
| ecc_b1 | output | 11 | Segment 1 word B |
| code0 | output | 22 | Segment 0 packed code |
| code1 | output | 22 | Segment 1 packed code |
| done | output | 1 | Unit complete; parity frozen |

## Verification
The hardest case to reach from the ports is a parity error that only shows up at a few bit locations. Examples are the top byte offset of the second segment, or a wrong boundary between the two segments. Whole pages of random data hide these, because many bits cancel. The stimulus therefore walks pages that are zero except for a single set bit. The set bit is placed at the extreme locations 0 and 2047 of each segment, at the segment boundary, and at offsets chosen so that each address bit toggles. The expected words are then just the location and its complement. A second run feeds random bytes with gaps in byte_valid, changes the seg512 input in the middle of a page, and puts a byte in the same cycle as a clear. The results are compared against a per-bit reference model.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic {
        SEG_SINGLE = 1'b0,
        SEG_DUAL   = 1'b1
    } seg_mode_e;

    localparam int NUM_SEG = 2;

endpackage

// File: rtl/nand_ecc_contrib.sv
module nand_ecc_contrib #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int PAR_W = ADDR_W + IDX_W
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  part_a,
    output logic [PAR_W-1:0]  part_b
);

    logic byte_par;

    always_comb begin
        byte_par = ^data;
        part_a   = '0;
        part_b   = '0;
        for (int k = 0; k < IDX_W; k++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (((i >> k) & 1) == 1)
                    part_a[k] = part_a[k] ^ data[i];
                else
                    part_b[k] = part_b[k] ^ data[i];
            end
        end
        for (int k = 0; k < ADDR_W; k++) begin
            part_a[IDX_W+k] = byte_addr[k] & byte_par;
            part_b[IDX_W+k] = ~byte_addr[k] & byte_par;
        end
    end

endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int SEG_BYTES = 256,
    localparam int ADDR_W = $clog2(SEG_BYTES),
    localparam int CNT_W  = $clog2(SEG_BYTES * NUM_SEG),
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               seg512,
    input  logic               byte_valid,
    output logic [NUM_SEG-1:0] seg_en,
    output logic [ADDR_W-1:0]  byte_addr,
    output logic               mode_dual,
    output logic               done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        seg_mode_e        mode;
        logic             done;
    } seq_t;

    seq_t             st_d, st_q;
    logic             accept;
    logic             last;
    logic [SEG_W-1:0] seg_idx;

    always_comb begin
        accept  = byte_valid && !st_q.done && !clr;
        last    = (st_q.mode == SEG_DUAL)
                  ? (st_q.cnt == CNT_W'(SEG_BYTES * NUM_SEG - 1))
                  : (st_q.cnt == CNT_W'(SEG_BYTES - 1));
        seg_idx = (st_q.mode == SEG_DUAL) ? SEG_W'(st_q.cnt >> ADDR_W) : '0;
        st_d    = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.mode = seg512 ? SEG_DUAL : SEG_SINGLE;
            st_d.done = 1'b0;
        end else if (accept) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.done = last;
        end
        for (int s = 0; s < NUM_SEG; s++)
            seg_en[s] = accept && (seg_idx == SEG_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.mode <= SEG_SINGLE;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_addr = st_q.cnt[ADDR_W-1:0];
    assign mode_dual = (st_q.mode == SEG_DUAL);
    assign done      = st_q.done;

endmodule

// File: rtl/nand_ecc_seg_acc.sv
module nand_ecc_seg_acc #(
    parameter int PAR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PAR_W-1:0] part_a,
    input  logic [PAR_W-1:0] part_b,
    output logic [PAR_W-1:0] word_a,
    output logic [PAR_W-1:0] word_b
);

    typedef struct packed {
        logic [PAR_W-1:0] a;
        logic [PAR_W-1:0] b;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d.a = '0;
            acc_d.b = '0;
        end else if (en) begin
            acc_d.a = acc_q.a ^ part_a;
            acc_d.b = acc_q.b ^ part_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign word_a = acc_q.a;
    assign word_b = acc_q.b;

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SEG_BYTES = 256,
    localparam int ADDR_W = $clog2(SEG_BYTES),
    localparam int PAR_W  = ADDR_W + $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                seg512,
    input  logic                byte_valid,
    input  logic [DATA_W-1:0]   byte_data,
    output logic [PAR_W-1:0]    ecc_a0,
    output logic [PAR_W-1:0]    ecc_b0,
    output logic [PAR_W-1:0]    ecc_a1,
    output logic [PAR_W-1:0]    ecc_b1,
    output logic [2*PAR_W-1:0]  code0,
    output logic [2*PAR_W-1:0]  code1,
    output logic                done
);

    logic [NUM_SEG-1:0] seg_en;
    logic [ADDR_W-1:0]  byte_addr;
    logic               mode_dual;
    logic [PAR_W-1:0]   part_a, part_b;
    logic [PAR_W-1:0]   word_a [NUM_SEG];
    logic [PAR_W-1:0]   word_b [NUM_SEG];

    nand_ecc_seq #(
        .SEG_BYTES (SEG_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .seg512     (seg512),
        .byte_valid (byte_valid),
        .seg_en     (seg_en),
        .byte_addr  (byte_addr),
        .mode_dual  (mode_dual),
        .done       (done)
    );

    nand_ecc_contrib #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_contrib (
        .byte_addr (byte_addr),
        .data      (byte_data),
        .part_a    (part_a),
        .part_b    (part_b)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        nand_ecc_seg_acc #(
            .PAR_W (PAR_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .en     (seg_en[s]),
            .part_a (part_a),
            .part_b (part_b),
            .word_a (word_a[s]),
            .word_b (word_b[s])
        );
    end

    assign ecc_a0 = word_a[0];
    assign ecc_b0 = word_b[0];
    assign ecc_a1 = word_a[1];
    assign ecc_b1 = word_b[1];
    assign code0  = {word_b[0], word_a[0]};
    assign code1  = {word_b[1], word_a[1]};

endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
    parameter int PAR_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             byte_valid,
    input logic             done,
    input logic             mode_dual,
    input logic [PAR_W-1:0] ecc_a0,
    input logic [PAR_W-1:0] ecc_b0,
    input logic [PAR_W-1:0] ecc_a1,
    input logic [PAR_W-1:0] ecc_b1
);

    // R8: a clear leaves every word zero and done low
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && ecc_a0 == '0 && ecc_b0 == '0 && ecc_a1 == '0 && ecc_b1 == '0));

    // R6: no valid byte, no change
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !clr) |=> ($stable(ecc_a0) && $stable(ecc_b0) &&
                                   $stable(ecc_a1) && $stable(ecc_b1) && $stable(done)));

    // R7: once done, words frozen until a clear
    p_done_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> (done && $stable(ecc_a0) && $stable(ecc_b0) &&
                            $stable(ecc_a1) && $stable(ecc_b1)));

    // R4: single mode never touches the second segment
    p_seg1_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dual |-> (ecc_a1 == '0 && ecc_b1 == '0));

    // R3: per bit position, A xor B equals the overall parity, so all bits agree
    p_pair_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((ecc_a0 ^ ecc_b0) == '0) || ((ecc_a0 ^ ecc_b0) == '1)) &&
        (((ecc_a1 ^ ecc_b1) == '0) || ((ecc_a1 ^ ecc_b1) == '1)));

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.PAR_W(PAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .byte_valid (byte_valid),
    .done       (done),
    .mode_dual  (mode_dual),
    .ecc_a0     (ecc_a0),
    .ecc_b0     (ecc_b0),
    .ecc_a1     (ecc_a1),
    .ecc_b1     (ecc_b1)
);

// File: tb/nand_ecc_gen_bench.sv
`timescale 1ns/1ps
module nand_ecc_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        seg512 = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [10:0] ecc_a0, ecc_b0, ecc_a1, ecc_b1;
    logic [21:0] code0, code1;
    logic        done;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nand_ecc_gen u_nand_ecc_gen (
        .clk (clk), .rst_n (rst_n), .clr (clr), .seg512 (seg512),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .ecc_a0 (ecc_a0), .ecc_b0 (ecc_b0), .ecc_a1 (ecc_a1), .ecc_b1 (ecc_b1),
        .code0 (code0), .code1 (code1), .done (done)
    );

    typedef struct packed {
        logic        dual;
        logic [8:0]  idx;
        logic [2:0]  bitn;
        logic [10:0] exp_a;
        logic [10:0] exp_b;
    } vec_t;

    // single set bit pages: expected word A = location, word B = its complement
    localparam vec_t VEC [8] = '{
        '{1'b0, 9'd0,   3'd0, 11'h000, 11'h7FF},
        '{1'b0, 9'd255, 3'd7, 11'h7FF, 11'h000},
        '{1'b0, 9'd3,   3'd5, 11'h01D, 11'h7E2},
        '{1'b0, 9'd128, 3'd1, 11'h401, 11'h3FE},
        '{1'b1, 9'd256, 3'd0, 11'h000, 11'h7FF},
        '{1'b1, 9'd511, 3'd7, 11'h7FF, 11'h000},
        '{1'b1, 9'd300, 3'd2, 11'h162, 11'h69D},
        '{1'b1, 9'd17,  3'd6, 11'h08E, 11'h771}
    };

    logic [7:0]  page [512];
    logic [10:0] ref_a [2];
    logic [10:0] ref_b [2];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_page(input logic dual);
        @(negedge clk);
        clr = 1'b1;
        seg512 = dual;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        byte_valid = 1'b1;
        byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // reference: per data bit, by the definition of the two words
    task automatic ref_calc(input logic dual, input int len);
        ref_a = '{default: '0};
        ref_b = '{default: '0};
        for (int n = 0; n < len; n++) begin
            int seg;
            int loc;
            seg = dual ? (n / 256) : 0;
            for (int i = 0; i < 8; i++) begin
                if (page[n][i]) begin
                    loc = (n % 256) * 8 + i;
                    for (int k = 0; k < 11; k++) begin
                        if (((loc >> k) & 1) == 1) ref_a[seg][k] = ~ref_a[seg][k];
                        else ref_b[seg][k] = ~ref_b[seg][k];
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  lfsr;
        logic [10:0] hold_a, hold_b;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 a0", ecc_a0, 0);
        chk("R1 b0", ecc_b0, 0);
        chk("R1 seg1", {ecc_a1, ecc_b1}, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: single set bit pages (R2, R3, R4, R5)
        foreach (VEC[v]) begin
            int len;
            int tseg;
            len = VEC[v].dual ? 512 : 256;
            tseg = VEC[v].dual ? int'(VEC[v].idx[8]) : 0;
            start_page(VEC[v].dual);
            for (int n = 0; n < len; n++) begin
                if (n == len - 1)
                    chk("R4/R5 done early", done, 0);
                send((n == int'(VEC[v].idx)) ? (8'h01 << VEC[v].bitn) : 8'h00);
            end
            chk("R4/R5 done", done, 1);
            chk("R2 word A", tseg ? ecc_a1 : ecc_a0, VEC[v].exp_a);
            chk("R3 word B", tseg ? ecc_b1 : ecc_b0, VEC[v].exp_b);
            chk("R5 other seg", tseg ? {ecc_a0, ecc_b0} : {ecc_a1, ecc_b1}, 0);
        end

        // random dual page with valid gaps (R5, R6, R9)
        lfsr = 8'hA5;
        for (int n = 0; n < 512; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            page[n] = lfsr;
        end
        ref_calc(1'b1, 512);
        start_page(1'b1);
        for (int n = 0; n < 512; n++) begin
            if (n % 7 == 3) begin
                hold_a = ecc_a0;
                hold_b = ecc_b1;
                byte_data = 8'hFF;
                @(negedge clk);
                chk("R6 idle a0", ecc_a0, hold_a);
                chk("R6 idle b1", ecc_b1, hold_b);
            end
            send(page[n]);
        end
        chk("R5 rand a0", ecc_a0, ref_a[0]);
        chk("R5 rand b0", ecc_b0, ref_b[0]);
        chk("R5 rand a1", ecc_a1, ref_a[1]);
        chk("R5 rand b1", ecc_b1, ref_b[1]);
        chk("R9 code0", code0, {ref_b[0], ref_a[0]});
        chk("R9 code1", code1, {ref_b[1], ref_a[1]});
        chk("R9 code0 low byte", code0[7:0], ref_a[0][7:0]);
        chk("R9 code1 top byte", code1[21:16], ref_b[1][10:5]);

        // R7: bytes after done ignored
        send(8'hFF);
        send(8'h3C);
        chk("R7 done held", done, 1);
        chk("R7 a0 frozen", ecc_a0, ref_a[0]);
        chk("R7 b1 frozen", ecc_b1, ref_b[1]);

        // R8: clear with a simultaneous byte drops it
        @(negedge clk);
        clr = 1'b1;
        seg512 = 1'b0;
        byte_valid = 1'b1;
        byte_data = 8'hFF;
        @(negedge clk);
        clr = 1'b0;
        byte_valid = 1'b0;
        chk("R8 cleared", {ecc_a0, ecc_b0, ecc_a1, ecc_b1}, 0);
        chk("R8 done low", done, 0);
        send(8'h01);
        chk("R8 count zero a0", ecc_a0, 11'h000);
        chk("R8 count zero b0", ecc_b0, 11'h7FF);

        // R4: mode taken at clear, seg512 change mid page ignored
        start_page(1'b0);
        seg512 = 1'b1;
        for (int n = 0; n < 256; n++)
            send((n == 200) ? 8'h80 : 8'h00);
        chk("R4 done at 256", done, 1);
        chk("R4 a0", ecc_a0, 11'h647);
        chk("R4 b0", ecc_b0, 11'h1B8);
        chk("R4 seg1 zero", {ecc_a1, ecc_b1}, 0);

        // R1: reset mid page
        start_page(1'b1);
        send(8'h5A);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset words", {ecc_a0, ecc_b0, ecc_a1, ecc_b1}, 0);
        chk("R1 reset done", done, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule